// File: doc/BRIEF.md
# NAND Page Copy Sequencer

This block moves a contiguous stretch of raw NAND flash into on-chip RAM, one page at a time, without software help. A single start pulse captures a destination RAM byte address, a flash source offset and a signed byte count. For every page the sequencer issues the read command, the column and row address bytes, waits for the flash to report ready, and then pulls one full page of data words over a read strobe. Each word is forwarded to a RAM write port whose address advances on its own.

The flash side is driven directly through chip enable (active low), command latch enable and address latch enable, with a write strobe and data bus. A fixed settle time follows each latch phase. Only the two row bytes of the working offset are sent; the column is always zero. With a 16-bit flash bus the offset is halved on capture. The page loop keeps going while the signed count stays non-negative after each page's 512-byte deduction, so the last page can run past the requested size. A ready wait that lasts too long ends the run with an error flag.

Top module: `nand_page_copier`

## Requirements
- R1: During and right after reset: `fl_ce_n_o`=1, `fl_cle_o`=0, `fl_ale_o`=0, `fl_we_o`=0, `fl_re_o`=0, `ram_we_o`=0, `busy_o`=0, `done_o`=0, `err_o`=0.
- R2: Each page opens with one write strobe carrying code 0x00 while `fl_ce_n_o`=0 and `fl_cle_o`=1; `fl_cle_o` is high for exactly SETTLE_CYC+1 cycles per page.
- R3: After command latch enable drops, three write strobes are issued with `fl_ale_o`=1, in this order: 0x00, bits [15:8] of the working offset, bits [23:16] of the working offset. With BUS16=1 the working offset starts as the start offset shifted right by one.
- R4: `fl_ale_o` is high for exactly SETTLE_CYC+3 cycles per page, and is low before any data is read.
- R5: No read strobe begins until `fl_rdy_i` has been sampled high after the address phase.
- R6: Each page yields 256 read strobes (BUS16=1) or 512 (BUS16=0); each strobe writes `fl_rdata_i` to RAM in the same cycle at an address that starts at the captured destination and rises by 2 (BUS16=1) or 1 (BUS16=0) per word, modulo 2^ADDR_W.
- R7: After each page the signed count drops by 512; another page follows while the result is non-negative. A non-negative start count N gives N/512+1 pages; a negative one gives one page.
- R8: After each page the working offset rises by 256 (BUS16=1) or 512 (BUS16=0), and the next page's row bytes reflect it.
- R9: After the final page `done_o` is high for exactly one cycle; in the following cycle `busy_o`=0 and `fl_ce_n_o`=1.
- R10: A start pulse while `busy_o`=1 has no effect on the run in progress.
- R11: If `fl_rdy_i` stays low for POLL_MAX cycles of the ready wait, the run aborts: `err_o`=1, `busy_o`=0, `fl_ce_n_o`=1, no `done_o`, no RAM write. `err_o` clears on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dst_addr_i | input | ADDR_W | Destination RAM byte address |
| src_off_i | input | OFF_W | Flash source offset |
| byte_cnt_i | input | CNT_W | Signed byte count (two's complement) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready-wait timeout flag |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_cle_o | output | 1 | Flash command latch enable |
| fl_ale_o | output | 1 | Flash address latch enable |
| fl_we_o | output | 1 | Flash bus write strobe |
| fl_wdata_o | output | BW | Flash write data (command or address byte, zero-extended) |
| fl_re_o | output | 1 | Flash read strobe |
| fl_rdata_i | input | BW | Flash read data, valid in the read-strobe cycle |
| fl_rdy_i | input | 1 | Flash ready (high) / busy (low) |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | RAM byte address |
| ram_wdata_o | output | BW | RAM write data |

## Verification
The assertions take for granted that the flash presents valid read data combinationally in the cycle of each read strobe and that the ready line changes only between clock edges. They also assume the source offset is at least 24 bits wide, so both row bytes exist. The bench flash model holds ready low from the last address byte through the settle time plus a per-vector delay kept under POLL_MAX, except in the one run meant to expire. It steps its data word only on clock edges where the read strobe is high.

// File: rtl/nand_copy_pkg.sv
package nand_copy_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD,
    S_SET1,
    S_COL,
    S_ROW1,
    S_ROW2,
    S_SET2,
    S_POLL,
    S_READ,
    S_PEND,
    S_FIN
  } nc_state_e;

  localparam logic [7:0] NC_READ_CMD   = 8'h00;
  localparam int         NC_PAGE_BYTES = 512;

endpackage

// File: rtl/nand_copy_timer.sv
// Counts cycles spent in the current state; cleared on each state change.
module nand_copy_timer #(
  parameter int SETTLE_CYC = 20,
  parameter int POLL_MAX   = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic settle_hit_o,
  output logic tout_hit_o
);

  localparam int LIM = (SETTLE_CYC > POLL_MAX) ? SETTLE_CYC : POLL_MAX;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (cnt_q != CW'(LIM))   cnt_q <= cnt_q + 1'b1;
  end

  assign settle_hit_o = (cnt_q == CW'(SETTLE_CYC - 1));
  assign tout_hit_o   = (cnt_q == CW'(POLL_MAX - 1));

endmodule

// File: rtl/nand_copy_track.sv
// Destination address, working offset, signed count and word index.
module nand_copy_track #(
  parameter bit BUS16  = 1'b1,
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              word_i,
  input  logic              page_i,
  output logic [ADDR_W-1:0] dst_o,
  output logic [7:0]        row_lo_o,
  output logic [7:0]        row_hi_o,
  output logic              last_word_o,
  output logic              stop_o
);
  import nand_copy_pkg::*;

  localparam int WORDS  = BUS16 ? 256 : 512;
  localparam int STEP   = BUS16 ? 2 : 1;
  localparam int PG_ADV = BUS16 ? 256 : 512;
  localparam int WI_W   = $clog2(WORDS);

  logic [ADDR_W-1:0] dst_q;
  logic [OFF_W-1:0]  off_q, off_ld;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [WI_W-1:0]   wi_q;

  generate
    if (BUS16) begin : g_half
      assign off_ld = off_i >> 1;
    end else begin : g_full
      assign off_ld = off_i;
    end
  endgenerate

  assign cnt_nxt = cnt_q - CNT_W'(NC_PAGE_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= '0;
      off_q <= '0;
      cnt_q <= '0;
      wi_q  <= '0;
    end else if (load_i) begin
      dst_q <= dst_i;
      off_q <= off_ld;
      cnt_q <= cnt_i;
      wi_q  <= '0;
    end else begin
      if (word_i) begin
        dst_q <= dst_q + ADDR_W'(STEP);
        wi_q  <= wi_q + 1'b1;
      end
      if (page_i) begin
        cnt_q <= cnt_nxt;
        off_q <= off_q + OFF_W'(PG_ADV);
      end
    end
  end

  assign dst_o       = dst_q;
  assign row_lo_o    = off_q[15:8];
  assign row_hi_o    = off_q[23:16];
  assign last_word_o = (wi_q == WI_W'(WORDS - 1));
  assign stop_o      = cnt_nxt[CNT_W-1];

  assert_dst_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_i && !load_i |=> dst_q == $past(dst_q) + ADDR_W'(STEP));

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_i && !load_i |=> cnt_q == $past(cnt_q) - CNT_W'(NC_PAGE_BYTES));

  assert_off_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_i && !load_i |=> off_q == $past(off_q) + OFF_W'(PG_ADV));

endmodule

// File: rtl/nand_page_copier.sv
module nand_page_copier #(
  parameter bit BUS16      = 1'b1,
  parameter int ADDR_W     = 24,
  parameter int OFF_W      = 32,
  parameter int CNT_W      = 24,
  parameter int SETTLE_CYC = 20,
  parameter int POLL_MAX   = 4096,
  localparam int BW        = BUS16 ? 16 : 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [OFF_W-1:0]  src_off_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              fl_ce_n_o,
  output logic              fl_cle_o,
  output logic              fl_ale_o,
  output logic              fl_we_o,
  output logic [BW-1:0]     fl_wdata_o,
  output logic              fl_re_o,
  input  logic [BW-1:0]     fl_rdata_i,
  input  logic              fl_rdy_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [BW-1:0]     ram_wdata_o
);
  import nand_copy_pkg::*;

  nc_state_e state_q, state_d;
  logic      err_q, err_d;
  logic      ld, word_stb, page_stb;
  logic      settle_hit, tout_hit;
  logic      last_word, stop;
  logic [7:0] row_lo, row_hi, wbyte;
  logic [ADDR_W-1:0] dst_cur;

  nand_copy_timer #(
    .SETTLE_CYC (SETTLE_CYC),
    .POLL_MAX   (POLL_MAX)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (state_d != state_q),
    .settle_hit_o (settle_hit),
    .tout_hit_o   (tout_hit)
  );

  nand_copy_track #(
    .BUS16  (BUS16),
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ld),
    .dst_i       (dst_addr_i),
    .off_i       (src_off_i),
    .cnt_i       (byte_cnt_i),
    .word_i      (word_stb),
    .page_i      (page_stb),
    .dst_o       (dst_cur),
    .row_lo_o    (row_lo),
    .row_hi_o    (row_hi),
    .last_word_o (last_word),
    .stop_o      (stop)
  );

  // next state
  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    ld       = 1'b0;
    word_stb = 1'b0;
    page_stb = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        ld      = 1'b1;
        err_d   = 1'b0;
        state_d = S_CMD;
      end
      S_CMD:  state_d = S_SET1;
      S_SET1: if (settle_hit) state_d = S_COL;
      S_COL:  state_d = S_ROW1;
      S_ROW1: state_d = S_ROW2;
      S_ROW2: state_d = S_SET2;
      S_SET2: if (settle_hit) state_d = S_POLL;
      S_POLL: begin
        if (fl_rdy_i) state_d = S_READ;
        else if (tout_hit) begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_READ: begin
        word_stb = 1'b1;
        if (last_word) state_d = S_PEND;
      end
      S_PEND: begin
        page_stb = 1'b1;
        state_d  = stop ? S_FIN : S_CMD;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  // bus byte per write phase
  always_comb begin
    unique case (state_q)
      S_ROW1:  wbyte = row_lo;
      S_ROW2:  wbyte = row_hi;
      S_CMD:   wbyte = NC_READ_CMD;
      default: wbyte = 8'h00;
    endcase
  end

  assign fl_ce_n_o   = (state_q == S_IDLE) || (state_q == S_FIN);
  assign fl_cle_o    = (state_q == S_CMD) || (state_q == S_SET1);
  assign fl_ale_o    = (state_q == S_COL) || (state_q == S_ROW1) ||
                       (state_q == S_ROW2) || (state_q == S_SET2);
  assign fl_we_o     = (state_q == S_CMD) || (state_q == S_COL) ||
                       (state_q == S_ROW1) || (state_q == S_ROW2);
  assign fl_wdata_o  = BW'(wbyte);
  assign fl_re_o     = (state_q == S_READ);
  assign ram_we_o    = (state_q == S_READ);
  assign ram_addr_o  = dst_cur;
  assign ram_wdata_o = fl_rdata_i;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign err_o       = err_q;

  assert_we_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o |-> (fl_cle_o != fl_ale_o) && !fl_ce_n_o);

  assert_cmd_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o && fl_cle_o |-> fl_wdata_o == BW'(NC_READ_CMD));

  assert_read_after_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_re_o) |-> $past(fl_rdy_i));

  assert_ram_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> fl_re_o && !fl_ale_o && !fl_cle_o && !fl_ce_n_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o && fl_ce_n_o);

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && start_i |=> busy_o);

  assert_abort_clean_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o && fl_ce_n_o && !done_o);

endmodule

// File: tb/nand_page_copier_tb_top.sv
`timescale 1ns/1ps
module nand_page_copier_tb_top;

  localparam int S     = 20;
  localparam int PM    = 64;
  localparam int AW    = 24;
  localparam int OW    = 32;
  localparam int CW    = 24;
  localparam int BW    = 16;
  localparam int WORDS = 256;

  // {dst[23:0], off[31:0], cnt[23:0], dly[7:0]}
  localparam logic [87:0] VEC [5] = '{
    {24'h000100, 32'h0001_2300, 24'h000000, 8'd0},
    {24'h000400, 32'h00AB_CD00, 24'h0001FF, 8'd3},
    {24'h001000, 32'h01FE_0200, 24'h000200, 8'd10},
    {24'h00FFFE, 32'h0000_0000, 24'h0005DC, 8'd1},
    {24'h000000, 32'h00FF_FF00, 24'hFFFFF9, 8'd40}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] dst_addr_i = '0;
  logic [OW-1:0] src_off_i = '0;
  logic [CW-1:0] byte_cnt_i = '0;
  logic          busy_o, done_o, err_o;
  logic          fl_ce_n_o, fl_cle_o, fl_ale_o, fl_we_o, fl_re_o;
  logic [BW-1:0] fl_wdata_o, fl_rdata_i;
  logic          fl_rdy_i = 1'b1;
  logic          ram_we_o;
  logic [AW-1:0] ram_addr_o;
  logic [BW-1:0] ram_wdata_o;

  nand_page_copier #(
    .BUS16 (1'b1), .ADDR_W (AW), .OFF_W (OW), .CNT_W (CW),
    .SETTLE_CYC (S), .POLL_MAX (PM)
  ) dut_i (
    .clk_i, .rst_ni, .start_i, .dst_addr_i, .src_off_i, .byte_cnt_i,
    .busy_o, .done_o, .err_o, .fl_ce_n_o, .fl_cle_o, .fl_ale_o, .fl_we_o,
    .fl_wdata_o, .fl_re_o, .fl_rdata_i, .fl_rdy_i, .ram_we_o, .ram_addr_o,
    .ram_wdata_o
  );

  always #10 clk_i = ~clk_i;

  int tb_tot = 0, tb_bad = 0, mon_tot = 0, mon_bad = 0;

  // run context, written by the main flow only
  logic          mon_en = 1'b0;
  logic [AW-1:0] cur_dst = '0;
  logic [OW-1:0] cur_off = '0;
  int            cur_dly = 0;
  bit            hang = 1'b0;

  // flash data model
  int rd_k = 0;
  always @(posedge clk_i) begin
    if (!mon_en)      rd_k <= 0;
    else if (fl_re_o) rd_k <= rd_k + 1;
  end
  assign fl_rdata_i = BW'(rd_k) ^ 16'hA5C3;

  // monitor state
  int mon_k, mon_pg, mon_ph, cle_tot, ale_tot, done_cnt, rdy_wait;

  task automatic mchk(input bit ok, input string tag, input longint act, input longint exp);
    mon_tot++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (!mon_en) begin
      mon_k = 0; mon_pg = 0; mon_ph = 0; cle_tot = 0; ale_tot = 0;
      done_cnt = 0; rdy_wait = 0; fl_rdy_i = 1'b1;
    end else begin
      logic [OW-1:0] w;
      logic [7:0]    eb;
      if (fl_re_o) mchk(fl_rdy_i, "R5 read strobe while not ready", fl_rdy_i, 1);
      if (ram_we_o) begin
        mchk(ram_addr_o == AW'(cur_dst + AW'(2 * mon_k)), "R6 ram address",
             ram_addr_o, AW'(cur_dst + AW'(2 * mon_k)));
        mchk(ram_wdata_o == (BW'(mon_k) ^ 16'hA5C3), "R6 ram data",
             ram_wdata_o, BW'(mon_k) ^ 16'hA5C3);
        mon_k++;
      end
      if (fl_cle_o) cle_tot++;
      if (fl_ale_o) ale_tot++;
      if (done_o)   done_cnt++;
      if (!fl_rdy_i && !hang) begin
        if (rdy_wait == 0) fl_rdy_i = 1'b1;
        else rdy_wait--;
      end
      if (fl_we_o) begin
        if (fl_cle_o) begin
          mchk(fl_wdata_o == 16'h0000 && !fl_ce_n_o, "R2 command write",
               fl_wdata_o, 0);
          mon_pg++;
          mon_ph = 0;
        end else begin
          w  = (cur_off >> 1) + OW'((mon_pg - 1) * 256);
          eb = (mon_ph == 0) ? 8'h00 : (mon_ph == 1) ? w[15:8] : w[23:16];
          mchk(fl_ale_o && fl_wdata_o == BW'(eb), "R3 R8 address byte",
               fl_wdata_o, eb);
          if (mon_ph == 2) begin
            fl_rdy_i = 1'b0;
            rdy_wait = S + cur_dly;
          end
          mon_ph++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tb_tot++;
    if (!ok) begin
      tb_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #2;
  endtask

  task automatic run_vec(input logic [87:0] v, input bit poke, input bit hold);
    int exp_pg;
    logic [CW-1:0] c;
    c       = v[31:8];
    cur_dst = v[87:64];
    cur_off = v[63:32];
    cur_dly = int'(v[7:0]);
    hang    = hold;
    exp_pg  = c[CW-1] ? 1 : int'(c) / 512 + 1;
    step();
    mon_en = 1'b1;
    step();
    start_i = 1'b1; dst_addr_i = cur_dst; src_off_i = cur_off; byte_cnt_i = c;
    step();
    start_i = 1'b0;
    chk(busy_o && !err_o, "R11 start accepted, error flag cleared", {busy_o, err_o}, 2'b10);
    for (int n = 0; n < 20000; n++) begin
      if (done_o || err_o) break;
      if (poke && n == 80) begin
        start_i = 1'b1; dst_addr_i = 24'h777770; src_off_i = 32'h0055_AA00;
        byte_cnt_i = 24'h000800;
      end
      if (poke && n == 81) start_i = 1'b0;
      step();
    end
    if (hold) begin
      chk(err_o && !busy_o && fl_ce_n_o, "R11 abort state", {err_o, busy_o, fl_ce_n_o}, 3'b101);
      step();
      chk(mon_k == 0 && done_cnt == 0, "R11 no ram write, no done", mon_k + done_cnt, 0);
      chk(ale_tot == S + 3, "R4 ale cycles before abort", ale_tot, S + 3);
    end else begin
      chk(done_o, "R9 done raised", done_o, 1);
      step();
      chk(!done_o && !busy_o && fl_ce_n_o, "R9 one-cycle done, idle bus",
          {done_o, busy_o, fl_ce_n_o}, 3'b001);
      chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
      chk(mon_pg == exp_pg, poke ? "R10 R7 page count" : "R7 page count", mon_pg, exp_pg);
      chk(mon_k == exp_pg * WORDS, poke ? "R10 R6 word count" : "R6 word count",
          mon_k, exp_pg * WORDS);
      chk(cle_tot == exp_pg * (S + 1), "R2 cle cycles", cle_tot, exp_pg * (S + 1));
      chk(ale_tot == exp_pg * (S + 3), "R4 ale cycles", ale_tot, exp_pg * (S + 3));
      chk(!err_o, "R11 no error on clean run", err_o, 0);
    end
    mon_en = 1'b0;
    hang   = 1'b0;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    tb_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", tb_tot + mon_tot + 1, tb_bad + mon_bad);
    $finish;
  end

  initial begin
    step();
    chk(fl_ce_n_o && !fl_cle_o && !fl_ale_o && !fl_we_o && !fl_re_o && !ram_we_o,
        "R1 flash pins in reset", {fl_ce_n_o, fl_cle_o, fl_ale_o, fl_we_o, fl_re_o, ram_we_o},
        6'b100000);
    chk(!busy_o && !done_o && !err_o, "R1 status in reset", {busy_o, done_o, err_o}, 0);
    step();
    rst_ni = 1'b1;
    step();
    step();
    chk(fl_ce_n_o && !fl_cle_o && !fl_ale_o && !fl_we_o && !fl_re_o && !busy_o,
        "R1 idle after reset", {fl_ce_n_o, fl_cle_o, fl_ale_o, fl_we_o, fl_re_o, busy_o},
        6'b100000);
    for (int i = 0; i < 5; i++) run_vec(VEC[i], i == 2, 1'b0);
    // ready never rises: timeout path, then error cleared by next run
    run_vec({24'h000200, 32'h0000_4400, 24'h000000, 8'd0}, 1'b0, 1'b1);
    chk(err_o, "R11 error held while idle", err_o, 1);
    run_vec(VEC[1], 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", tb_tot + mon_tot, tb_bad + mon_bad);
    $finish;
  end

endmodule